// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of a small out-of-order machine that has no bypass network. It accepts one decoded instruction per cycle: an operation kind, a destination register and two source registers. It binds that instruction to a free functional unit of the right kind. It then tells each unit when to read its operands from the register file and when to write its result back. Every produced value goes through the register file. A consumer therefore reads a value only after its producer has written it.

The block keeps one tracking slot per functional unit and one pending-writer entry per architectural register. The unit mix is fixed: one integer/load unit (index 0), two multipliers (1 and 2), one adder/subtractor (3) and one divider (4).

Each unit slot runs a four-state machine:
- IDLE moves to OPWAIT when an instruction is dispatched into the slot.
- OPWAIT moves to EXEC in the cycle both source-ready flags are set. That cycle is the operand-read grant, and both flags are cleared on leaving.
- EXEC moves to WBWAIT when the unit reports that execution is done.
- WBWAIT moves back to IDLE when the write grant is given, which frees the slot and its register entry.

The slot records:
- the destination register;
- both source registers;
- the producing unit for each source;
- a ready flag for each source.

A write broadcast sets the ready flag of every waiting source whose producer is the writing unit.

Dispatch is held back in two cases. The first is when no unit of the requested kind is free, which is a structural hazard. The second is when any outstanding instruction already owns the destination register, which is an output hazard. A finished unit's write is held back while any other slot still waiting for operands has a ready, unread source equal to the register being written, which is an anti-dependence. Among the units allowed to write, the lowest index wins, and only one write is made per cycle.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset, no unit is busy: `rd_grant`, `wr_grant` and `rf_we` are all 0, and a valid dispatch of any kind is accepted without stall.
- R2: `disp_kind` encoding: 0 is integer/load (unit 0), 1 is multiply (unit 1 if free, else unit 2), 2 is add/sub (unit 3), 3 is divide (unit 4). On acceptance, `disp_unit` is the one-hot bit of the chosen unit in the same cycle.
- R3: If every unit of the requested kind is busy, `disp_stall` is 1 and `disp_unit` is 0. The stalled instruction leaves no trace: its destination is not marked as pending.
- R4: A dispatch whose destination has a pending writer stalls. It is accepted in the cycle after that writer's write grant.
- R5: A unit whose sources have no pending writer gets `rd_grant` in the cycle after dispatch, for exactly one cycle. A unit with an unready source gets no `rd_grant`.
- R6: With no contention, `exec_done` in cycle e gives `wr_grant` in cycle e+1. A consumer waiting on that result gets `rd_grant` in cycle e+2.
- R7: A dispatch in the same cycle as the write grant of its source's producer treats that source as ready, so `rd_grant` follows in the next cycle.
- R8: A unit in WBWAIT gets no `wr_grant` while another unit in OPWAIT has a ready source equal to its destination. The grant comes in the cycle after that reader's `rd_grant`, and other units may write meanwhile.
- R9: When several units may write, only the lowest-indexed one is granted in a cycle; the others follow in later cycles.
- R10: `rf_we` is 1 exactly in cycles with a write grant. `rf_waddr` is then the destination of the granted unit.
- R11: `exec_done` on a unit that is not executing has no effect: no write grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Decoded instruction offered |
| disp_kind | input | 2 | Operation kind (see R2) |
| disp_dst | input | REG_W | Destination register |
| disp_src1 | input | REG_W | First source register |
| disp_src2 | input | REG_W | Second source register |
| disp_stall | output | 1 | Offered instruction held back this cycle |
| disp_unit | output | NUM_FU | One-hot unit receiving the instruction |
| rd_grant | output | NUM_FU | Per-unit operand read grant |
| exec_done | input | NUM_FU | Per-unit end of execution |
| wr_grant | output | NUM_FU | Per-unit result write grant |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_W | Register-file write address |

## Verification
The hardest situation to reach from the ports is the anti-dependence hold. It needs a reader sitting in OPWAIT with one source ready and equal to a finished writer's destination, while its other source waits on a third, slower unit. The bench builds this with three dispatches: a multiply, then a divide that reads the multiply's result and the contested register, then an add that overwrites that register. The add finishes first. The multiply then finishes while the add is held, which shows both that the hold stays in place and that the unblocked multiply writes ahead of it. A sweep over every register repeats the output-hazard stall and the producer-to-consumer timing, once for each register.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_FU = 5;
    localparam int FU_W   = $clog2(NUM_FU);

    localparam int U_INT   = 0;
    localparam int U_MUL_A = 1;
    localparam int U_MUL_B = 2;
    localparam int U_ADD   = 3;
    localparam int U_DIV   = 4;

    typedef enum logic [1:0] {
        K_INT = 2'd0,
        K_MUL = 2'd1,
        K_ADD = 2'd2,
        K_DIV = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPWAIT,
        ST_EXEC,
        ST_WBWAIT
    } fu_state_e;

    function automatic logic [FU_W-1:0] fu_index(input logic [NUM_FU-1:0] oh);
        logic [FU_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (oh[i]) idx = idx | FU_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] ld_dst,
    input  logic [REG_W-1:0] ld_src1,
    input  logic [REG_W-1:0] ld_src2,
    input  logic [FU_W-1:0]  ld_q1,
    input  logic [FU_W-1:0]  ld_q2,
    input  logic             ld_r1,
    input  logic             ld_r2,
    input  logic             wb_valid,
    input  logic [FU_W-1:0]  wb_unit,
    input  logic             exec_done,
    input  logic             wr_grant,
    output logic             busy,
    output logic             rd_grant,
    output logic             want_wr,
    output logic             op_wait,
    output logic [REG_W-1:0] dst,
    output logic [REG_W-1:0] src1,
    output logic [REG_W-1:0] src2,
    output logic             r1,
    output logic             r2
);
    fu_state_e        state, state_nx;
    logic [REG_W-1:0] dst_q, src1_q, src2_q;
    logic [FU_W-1:0]  q1_q, q2_q;
    logic             r1_q, r2_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (load)          state_nx = ST_OPWAIT;
            ST_OPWAIT: if (r1_q && r2_q)  state_nx = ST_EXEC;
            ST_EXEC:   if (exec_done)     state_nx = ST_WBWAIT;
            ST_WBWAIT: if (wr_grant)      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        op_wait  = (state == ST_OPWAIT);
        rd_grant = (state == ST_OPWAIT) && r1_q && r2_q;
        want_wr  = (state == ST_WBWAIT);
        dst      = dst_q;
        src1     = src1_q;
        src2     = src2_q;
        r1       = r1_q;
        r2       = r2_q;
    end

    // slot fields and wake-up on write broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            src1_q <= '0;
            src2_q <= '0;
            q1_q   <= '0;
            q2_q   <= '0;
            r1_q   <= 1'b0;
            r2_q   <= 1'b0;
        end else if (load) begin
            dst_q  <= ld_dst;
            src1_q <= ld_src1;
            src2_q <= ld_src2;
            q1_q   <= ld_q1;
            q2_q   <= ld_q2;
            r1_q   <= ld_r1;
            r2_q   <= ld_r2;
        end else if (state == ST_OPWAIT) begin
            if (r1_q && r2_q) begin
                r1_q <= 1'b0;
                r2_q <= 1'b0;
            end else if (wb_valid) begin
                if (!r1_q && (q1_q == wb_unit)) r1_q <= 1'b1;
                if (!r2_q && (q2_q == wb_unit)) r2_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_dispatch.sv
module sb_dispatch
    import sb_pkg::*;
(
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic [NUM_FU-1:0] unit_busy,
    input  logic              waw_hit,
    output logic [NUM_FU-1:0] sel,
    output logic              stall
);
    logic [NUM_FU-1:0] cand;

    always_comb begin
        cand = '0;
        unique case (op_kind_e'(disp_kind))
            K_INT: cand[U_INT] = !unit_busy[U_INT];
            K_MUL: begin
                if (!unit_busy[U_MUL_A]) cand[U_MUL_A] = 1'b1;
                else                     cand[U_MUL_B] = !unit_busy[U_MUL_B];
            end
            K_ADD: cand[U_ADD] = !unit_busy[U_ADD];
            K_DIV: cand[U_DIV] = !unit_busy[U_DIV];
        endcase
        stall = disp_valid && ((cand == '0) || waw_hit);
        sel   = (disp_valid && !stall) ? cand : '0;
    end
endmodule

// File: rtl/sb_wr_arbiter.sv
module sb_wr_arbiter
    import sb_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [NUM_FU-1:0]            want,
    input  logic [NUM_FU-1:0]            op_wait,
    input  logic [NUM_FU-1:0]            r1,
    input  logic [NUM_FU-1:0]            r2,
    input  logic [NUM_FU-1:0][REG_W-1:0] dst,
    input  logic [NUM_FU-1:0][REG_W-1:0] src1,
    input  logic [NUM_FU-1:0][REG_W-1:0] src2,
    output logic [NUM_FU-1:0]            grant
);
    logic [NUM_FU-1:0] blocked;
    logic [NUM_FU-1:0] eligible;
    logic              found;

    // anti-dependence hold: an unread ready source matches the write target
    always_comb begin
        blocked = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            for (int x = 0; x < NUM_FU; x++) begin
                if (x != u && op_wait[x] &&
                    ((r1[x] && src1[x] == dst[u]) || (r2[x] && src2[x] == dst[u])))
                    blocked[u] = 1'b1;
            end
        end
        eligible = want & ~blocked;
    end

    // fixed priority, lowest index first
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (eligible[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int REG_COUNT = 16,
    localparam int REG_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic [REG_W-1:0]  disp_dst,
    input  logic [REG_W-1:0]  disp_src1,
    input  logic [REG_W-1:0]  disp_src2,
    output logic              disp_stall,
    output logic [NUM_FU-1:0] disp_unit,
    output logic [NUM_FU-1:0] rd_grant,
    input  logic [NUM_FU-1:0] exec_done,
    output logic [NUM_FU-1:0] wr_grant,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr
);
    // pending-writer table
    logic [REG_COUNT-1:0]           rs_busy;
    logic [REG_COUNT-1:0][FU_W-1:0] rs_unit;

    logic [NUM_FU-1:0]            busy_v, want_v, opw_v, r1_v, r2_v;
    logic [NUM_FU-1:0][REG_W-1:0] dst_v, src1_v, src2_v;

    logic             wb_valid;
    logic [FU_W-1:0]  wb_unit;
    logic [REG_W-1:0] wb_dst;
    logic [FU_W-1:0]  disp_idx;
    logic [FU_W-1:0]  ld_q1, ld_q2;
    logic             ld_r1, ld_r2;

    always_comb begin
        wb_valid = |wr_grant;
        wb_unit  = fu_index(wr_grant);
        wb_dst   = dst_v[wb_unit];
        disp_idx = fu_index(disp_unit);
        ld_q1    = rs_unit[disp_src1];
        ld_q2    = rs_unit[disp_src2];
        ld_r1    = !rs_busy[disp_src1] || (wb_valid && ld_q1 == wb_unit);
        ld_r2    = !rs_busy[disp_src2] || (wb_valid && ld_q2 == wb_unit);
        rf_we    = wb_valid;
        rf_waddr = wb_dst;
    end

    sb_dispatch u_disp (
        .disp_valid (disp_valid),
        .disp_kind  (disp_kind),
        .unit_busy  (busy_v),
        .waw_hit    (rs_busy[disp_dst]),
        .sel        (disp_unit),
        .stall      (disp_stall)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
        sb_fu_entry #(.REG_W(REG_W)) u_fu (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (disp_unit[g]),
            .ld_dst    (disp_dst),
            .ld_src1   (disp_src1),
            .ld_src2   (disp_src2),
            .ld_q1     (ld_q1),
            .ld_q2     (ld_q2),
            .ld_r1     (ld_r1),
            .ld_r2     (ld_r2),
            .wb_valid  (wb_valid),
            .wb_unit   (wb_unit),
            .exec_done (exec_done[g]),
            .wr_grant  (wr_grant[g]),
            .busy      (busy_v[g]),
            .rd_grant  (rd_grant[g]),
            .want_wr   (want_v[g]),
            .op_wait   (opw_v[g]),
            .dst       (dst_v[g]),
            .src1      (src1_v[g]),
            .src2      (src2_v[g]),
            .r1        (r1_v[g]),
            .r2        (r2_v[g])
        );
    end

    sb_wr_arbiter #(.REG_W(REG_W)) u_arb (
        .want    (want_v),
        .op_wait (opw_v),
        .r1      (r1_v),
        .r2      (r2_v),
        .dst     (dst_v),
        .src1    (src1_v),
        .src2    (src2_v),
        .grant   (wr_grant)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_busy <= '0;
            rs_unit <= '0;
        end else begin
            if (wb_valid) rs_busy[wb_dst] <= 1'b0;
            if (|disp_unit) begin
                rs_busy[disp_dst] <= 1'b1;
                rs_unit[disp_dst] <= disp_idx;
            end
        end
    end
endmodule

// File: rtl/sb_sva.sv
module sb_sva
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic              disp_stall,
    input logic [NUM_FU-1:0] disp_unit,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wr_grant,
    input logic [NUM_FU-1:0] busy,
    input logic [NUM_FU-1:0] want
);
    // R9
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));
    // R2
    disp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_unit));
    // R3
    stall_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> (disp_unit == '0));
    // R4
    stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> disp_valid);

    for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
        // R5
        rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> !rd_grant[g]);
        // R2
        free_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            disp_unit[g] |-> !busy[g]);
        // R11
        grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[g] |-> want[g]);
        // R10
        release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[g] |=> !busy[g]);
    end
endmodule

bind sb_scoreboard sb_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_stall (disp_stall),
    .disp_unit  (disp_unit),
    .rd_grant   (rd_grant),
    .wr_grant   (wr_grant),
    .busy       (busy_v),
    .want       (want_v)
);

// File: tb/tb_sb_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       disp_valid;
    logic [1:0] disp_kind;
    logic [3:0] disp_dst, disp_src1, disp_src2;
    logic       disp_stall;
    logic [4:0] disp_unit, rd_grant, exec_done, wr_grant;
    logic       rf_we;
    logic [3:0] rf_waddr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sb_scoreboard #(.REG_COUNT(16)) dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_kind(disp_kind),
        .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_src2(disp_src2),
        .disp_stall(disp_stall), .disp_unit(disp_unit), .rd_grant(rd_grant),
        .exec_done(exec_done), .wr_grant(wr_grant), .rf_we(rf_we), .rf_waddr(rf_waddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic put(input int k, input int d, input int a, input int b);
        disp_valid = 1'b1;
        disp_kind  = k[1:0];
        disp_dst   = d[3:0];
        disp_src1  = a[3:0];
        disp_src2  = b[3:0];
    endtask

    // one instruction through all four states, sources free
    task automatic run_single(input int k, input int u, input int d);
        nedge(); put(k, d, 14, 15); #1;
        chk("R2 route", disp_unit, 32'(1 << u));
        chk("R2 no stall", disp_stall, 0);
        nedge(); disp_valid = 1'b0; #1;
        chk("R5 read grant", rd_grant, 32'(1 << u));
        nedge(); #1;
        chk("R5 single grant", rd_grant, 0);
        exec_done = 5'(1 << u);
        nedge(); exec_done = '0; #1;
        chk("R6 write grant", wr_grant, 32'(1 << u));
        chk("R10 write addr", rf_waddr, 32'(d));
        chk("R10 write en", rf_we, 1);
        nedge(); #1;
        chk("R10 write end", rf_we, 0);
    endtask

    initial begin
        rst_n = 1'b0; disp_valid = 1'b0; disp_kind = '0;
        disp_dst = '0; disp_src1 = '0; disp_src2 = '0; exec_done = '0;
        repeat (3) nedge();
        rst_n = 1'b1; #1;
        chk("R1 rd_grant", rd_grant, 0);
        chk("R1 wr_grant", wr_grant, 0);
        chk("R1 rf_we", rf_we, 0);
        put(3, 7, 1, 2); #1;
        chk("R1 accept", disp_stall, 0);
        disp_valid = 1'b0;

        // R2 routing for every kind
        run_single(0, 0, 1);
        run_single(1, 1, 2);
        run_single(2, 3, 3);
        run_single(3, 4, 4);

        // R3 structural stall, R9 priority, R11 stray done
        nedge(); put(1, 1, 14, 15); #1; chk("R2 mul A", disp_unit, 5'b00010);
        nedge(); put(1, 2, 14, 15); #1; chk("R2 mul B", disp_unit, 5'b00100);
        nedge(); put(1, 3, 14, 15); #1;
        chk("R3 stall", disp_stall, 1);
        chk("R3 no unit", disp_unit, 0);
        nedge(); disp_valid = 1'b0; exec_done = 5'b10110;
        nedge(); exec_done = '0; #1;
        chk("R9 first", wr_grant, 5'b00010);
        chk("R10 addr1", rf_waddr, 1);
        nedge(); #1;
        chk("R9 second", wr_grant, 5'b00100);
        chk("R10 addr2", rf_waddr, 2);
        nedge(); #1;
        chk("R11 idle done ignored", wr_grant, 0);
        put(2, 5, 3, 3);
        nedge(); disp_valid = 1'b0; #1;
        chk("R3 not recorded", rd_grant, 5'b01000);
        nedge(); exec_done = 5'b01000;
        nedge(); exec_done = '0; #1;
        chk("R10 addr5", rf_waddr, 5);

        // RAW chain with WAW stall
        nedge(); put(0, 6, 14, 15); #1; chk("R2 load", disp_unit, 5'b00001);
        nedge(); put(1, 0, 6, 4); #1;
        chk("R5 load reads", rd_grant, 5'b00001);
        chk("R2 mul", disp_unit, 5'b00010);
        nedge(); put(2, 6, 2, 2); exec_done = 5'b00001; #1;
        chk("R4 waw stall", disp_stall, 1);
        chk("R5 hold", rd_grant, 0);
        nedge(); exec_done = '0; #1;
        chk("R6 wb e+1", wr_grant, 5'b00001);
        chk("R10 addr6", rf_waddr, 6);
        chk("R4 still stalled", disp_stall, 1);
        nedge(); #1;
        chk("R6 consumer e+2", rd_grant, 5'b00010);
        chk("R4 release", disp_unit, 5'b01000);
        nedge(); disp_valid = 1'b0; #1;
        chk("R5 add reads", rd_grant, 5'b01000);
        nedge(); exec_done = 5'b01010;
        nedge(); exec_done = '0; #1;
        chk("R9 mul first", wr_grant, 5'b00010);
        nedge(); #1;
        chk("R9 add next", wr_grant, 5'b01000);
        nedge(); #1;
        chk("R9 drained", wr_grant, 0);

        // R7 same-cycle source release
        nedge(); put(0, 5, 14, 15);
        nedge(); disp_valid = 1'b0;
        nedge(); exec_done = 5'b00001;
        nedge(); exec_done = '0; put(2, 9, 5, 14); #1;
        chk("R7 producer writes", wr_grant, 5'b00001);
        chk("R7 accepted", disp_unit, 5'b01000);
        nedge(); disp_valid = 1'b0; #1;
        chk("R7 reads next", rd_grant, 5'b01000);
        nedge(); exec_done = 5'b01000;
        nedge(); exec_done = '0; #1;
        chk("R10 addr9", rf_waddr, 9);

        // R8 anti-dependence hold
        nedge(); put(1, 0, 1, 1); #1; chk("R2 mul", disp_unit, 5'b00010);
        nedge(); put(3, 10, 0, 6); #1; chk("R2 div", disp_unit, 5'b10000);
        nedge(); put(2, 6, 2, 2); #1; chk("R2 add", disp_unit, 5'b01000);
        nedge(); disp_valid = 1'b0; #1;
        chk("R5 only add reads", rd_grant, 5'b01000);
        nedge(); exec_done = 5'b01000;
        nedge(); exec_done = 5'b00010; #1;
        chk("R8 held", wr_grant, 0);
        chk("R8 no write", rf_we, 0);
        nedge(); exec_done = '0; #1;
        chk("R8 other writes", wr_grant, 5'b00010);
        nedge(); #1;
        chk("R6 div reads", rd_grant, 5'b10000);
        chk("R8 still held", wr_grant, 0);
        nedge(); #1;
        chk("R8 released", wr_grant, 5'b01000);
        chk("R10 addr6b", rf_waddr, 6);
        nedge(); exec_done = 5'b10000;
        nedge(); exec_done = '0; #1;
        chk("R10 addr10", rf_waddr, 10);
        nedge(); #1;
        chk("R8 drained", wr_grant, 0);

        // sweep every register: WAW stall and producer/consumer timing
        for (int r = 0; r < 16; r++) begin
            int s;
            s = (r + 5) % 16;
            nedge(); put(0, r, r, r); #1;
            chk("R2 sweep load", disp_unit, 5'b00001);
            nedge(); put(2, r, r, r); #1;
            chk("R4 sweep stall", disp_stall, 1);
            nedge(); put(2, s, r, s); exec_done = 5'b00001; #1;
            chk("R4 sweep other dst", disp_unit, 5'b01000);
            nedge(); disp_valid = 1'b0; exec_done = '0; #1;
            chk("R10 sweep addr r", rf_waddr, 32'(r));
            nedge(); #1;
            chk("R6 sweep consumer", rd_grant, 5'b01000);
            nedge(); exec_done = 5'b01000;
            nedge(); exec_done = '0; #1;
            chk("R10 sweep addr s", rf_waddr, 32'(s));
        end

        nedge();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule